// File: doc/BRIEF.md
# Circular Pattern Clock Synthesizer

This block turns a fast reference clock (160 MHz in the intended system) into a test clock or an arbitrary pulse train on one output pin. Two programmable dividers run in cascade. The first counts reference cycles. The second counts the first one's enable pulses. Each enable from the second divider is one bit-clock tick. On every tick, one bit is taken from a circular pattern store of 32-bit words and registered onto the pin. The period of each bit is therefore the product of the two divider values.

Software writes the pattern words through an address/data port while the block is idle. It then sets the two divider values, the count of bits used from each word, and the number of words in the loop, and pulses start. After that the pattern repeats forever without help. For a plain clock, each output period is a run of ones (mark) followed by a run of zeros (space). The duty cycle is set by those two run lengths. The loop length is chosen so that a whole number of periods fits in it, so the wrap is seamless.

The store is built from several equal sub-banks that are read back to back. The divider and bit-count ranges reach from 20 MHz (8 reference cycles per period) down to below 2 Hz: 256 × 256 × 32 × 64 reference cycles is more than 80 M.

Top module: `pattern_clk_synth`

## Requirements
- R1: While reset is high, and afterwards until a start pulse is seen, `pat_out` is 0.
- R2: A configuration write uses `cfg_sel` 0 for the first divider and 1 for the second, with the value minus one in `cfg_data[7:0]`. Consecutive output bits are then spaced exactly D1·D2 reference cycles apart. `pat_out` changes only when a bit is emitted, or on start, stop or reset.
- R3: Bits leave each word most significant bit first. The first bit after the start edge is bit 31 of word 0, and it appears at the clock edge D1·D2 cycles after that start edge.
- R4: `cfg_sel` 2 with B−1 in `cfg_data[4:0]` makes only the top B bits of each word play (bits 31 down to 32−B) before the next word begins.
- R5: `cfg_sel` 3 with L−1 in `cfg_data[5:0]` sets the loop length. After word L−1, playback goes on at word 0 with no gap and no extra bit.
- R6: The move from the last word of one sub-bank to the first word of the next (word 15 to word 16 by default) neither drops nor adds a bit.
- R7: A stop pulse forces `pat_out` to 0 at the next edge, and it stays 0 after that. When start and stop are high together, stop wins.
- R8: While running, configuration writes and pattern writes are ignored. The stream keeps the values it was started with.
- R9: A start pulse while running restarts from bit 31 of word 0 and clears both divider counts. The next bit appears D1·D2 cycles after that edge.
- R10: Each divider accepts values from 1 to 256. A value of 1 lets every input tick through, and 256 passes one input tick in 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: begin or restart playback |
| stop | input | 1 | One-cycle pulse: halt playback, output low |
| cfg_we | input | 1 | Configuration write strobe (honoured only when idle) |
| cfg_sel | input | 2 | 0 divider A, 1 divider B, 2 bits per word, 3 loop length |
| cfg_data | input | 8 | Configuration value, minus one |
| buf_we | input | 1 | Pattern word write strobe (honoured only when idle) |
| buf_addr | input | 6 | Pattern word address |
| buf_wdata | input | 32 | Pattern word data |
| pat_out | output | 1 | Registered pattern output |

## Verification
The stream is tried with random words under random divider pairs, bit counts and loop lengths. These runs tell apart wrong bit order, wrong word stepping and wrong wrap points. A mark/space clock pattern checks that the duty cycle comes only from the stored run lengths. Extreme divider settings (1×256 and 256×1) separate the two dividers' counting from each other. Short bit counts with long loops run across the sub-bank seam. Writes injected mid-run, a mid-run restart, and stop raised together with start tell apart the ignore, restart and priority rules.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    parameter int WORD_W     = 32;
    parameter int DEPTH      = 64;
    parameter int BANK_WORDS = 16;
    parameter int DIV_W      = 8;

    localparam int ADDR_W    = $clog2(DEPTH);
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int NUM_BANKS = DEPTH / BANK_WORDS;

    typedef enum logic [1:0] {
        SEL_DIV_A = 2'd0,
        SEL_DIV_B = 2'd1,
        SEL_BPW   = 2'd2,
        SEL_LEN   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [DIV_W-1:0]  div_a_m1;
        logic [DIV_W-1:0]  div_b_m1;
        logic [BIT_W-1:0]  bpw_m1;
        logic [ADDR_W-1:0] len_m1;
    } cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] word;
        logic [BIT_W-1:0]  bit_idx;
    } play_pos_t;

    function automatic play_pos_t advance(input play_pos_t p, input cfg_t c);
        play_pos_t n;
        n = p;
        if (p.bit_idx == c.bpw_m1) begin
            n.bit_idx = '0;
            n.word    = (p.word == c.len_m1) ? '0 : p.word + 1'b1;
        end else begin
            n.bit_idx = p.bit_idx + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/pcs_tick_div.sv
module pcs_tick_div #(
    parameter int W = pcs_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en_in,
    input  logic [W-1:0] lim,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = en_in && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en_in) begin
            cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcs_bank_mem.sv
module pcs_bank_mem #(
    parameter int WORD_W     = pcs_pkg::WORD_W,
    parameter int DEPTH      = pcs_pkg::DEPTH,
    parameter int BANK_WORDS = pcs_pkg::BANK_WORDS
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WORD_W-1:0]        rdata
);
    localparam int AW      = $clog2(DEPTH);
    localparam int BANK_AW = $clog2(BANK_WORDS);
    localparam int NBANK   = DEPTH / BANK_WORDS;

    generate
        if (NBANK > 1) begin : g_multi
            localparam int SEL_W = AW - BANK_AW;
            logic [WORD_W-1:0]  bank_q [NBANK];
            logic [SEL_W-1:0]   wsel, rsel;
            logic [BANK_AW-1:0] woff, roff;

            assign wsel = waddr[AW-1 -: SEL_W];
            assign rsel = raddr[AW-1 -: SEL_W];
            assign woff = waddr[BANK_AW-1:0];
            assign roff = raddr[BANK_AW-1:0];

            for (genvar b = 0; b < NBANK; b++) begin : g_bank
                logic [WORD_W-1:0] arr [BANK_WORDS];
                always_ff @(posedge clk) begin
                    if (we && (wsel == SEL_W'(b))) begin
                        arr[woff] <= wdata;
                    end
                end
                assign bank_q[b] = arr[roff];
            end

            assign rdata = bank_q[rsel];
        end else begin : g_single
            logic [WORD_W-1:0] arr [DEPTH];
            always_ff @(posedge clk) begin
                if (we) begin
                    arr[waddr] <= wdata;
                end
            end
            assign rdata = arr[raddr];
        end
    endgenerate
endmodule

// File: rtl/pcs_player.sv
module pcs_player
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              start,
    input  logic              stop,
    input  logic              bit_tick,
    input  cfg_t              cfg,
    input  logic [WORD_W-1:0] word_q,
    output play_pos_t         pos,
    output logic              pat_o
);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    logic [BIT_W-1:0] sel_bit;
    assign sel_bit = TOP_BIT - pos.bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            pat_o <= 1'b0;
        end else if (stop || start) begin
            pos   <= '0;
            pat_o <= 1'b0;
        end else if (!run) begin
            pat_o <= 1'b0;
        end else if (bit_tick) begin
            pat_o <= word_q[sel_bit];
            pos   <= advance(pos, cfg);
        end
    end
endmodule

// File: rtl/pattern_clk_synth.sv
module pattern_clk_synth
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DIV_W-1:0]  cfg_data,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [WORD_W-1:0] buf_wdata,
    output logic              pat_out
);
    logic              running;
    cfg_t              cfg_q;
    logic              tick_a, tick_b;
    logic              div_clr;
    play_pos_t         pos_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cfg_q   <= '0;
        end else begin
            if (stop) begin
                running <= 1'b0;
            end else if (start) begin
                running <= 1'b1;
            end
            if (!running && cfg_we) begin
                case (cfg_sel_e'(cfg_sel))
                    SEL_DIV_A: cfg_q.div_a_m1 <= cfg_data;
                    SEL_DIV_B: cfg_q.div_b_m1 <= cfg_data;
                    SEL_BPW:   cfg_q.bpw_m1   <= cfg_data[BIT_W-1:0];
                    SEL_LEN:   cfg_q.len_m1   <= cfg_data[ADDR_W-1:0];
                    default:   cfg_q          <= cfg_q;
                endcase
            end
        end
    end

    assign div_clr = start || !running;

    pcs_tick_div #(.W(DIV_W)) u_div_a (
        .clk   (clk),
        .rst   (rst),
        .clr   (div_clr),
        .en_in (running),
        .lim   (cfg_q.div_a_m1),
        .tick  (tick_a)
    );

    pcs_tick_div #(.W(DIV_W)) u_div_b (
        .clk   (clk),
        .rst   (rst),
        .clr   (div_clr),
        .en_in (tick_a),
        .lim   (cfg_q.div_b_m1),
        .tick  (tick_b)
    );

    pcs_bank_mem #(
        .WORD_W     (WORD_W),
        .DEPTH      (DEPTH),
        .BANK_WORDS (BANK_WORDS)
    ) u_mem (
        .clk   (clk),
        .we    (buf_we && !running),
        .waddr (buf_addr),
        .wdata (buf_wdata),
        .raddr (pos_q.word),
        .rdata (word_q)
    );

    pcs_player u_play (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .start    (start),
        .stop     (stop),
        .bit_tick (tick_b),
        .cfg      (cfg_q),
        .word_q   (word_q),
        .pos      (pos_q),
        .pat_o    (pat_out)
    );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
    import pcs_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      start,
    input logic      stop,
    input logic      pat_out,
    input logic      running,
    input logic      tick_a,
    input logic      tick_b,
    input cfg_t      cfg,
    input play_pos_t pos
);
    p_reset_low_r1: assert property (@(posedge clk) rst |=> !pat_out);

    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        !running |-> !pat_out);

    p_stop_low_r7: assert property (@(posedge clk) disable iff (rst)
        stop |=> !pat_out);

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_b && !start && !stop) |=> $stable(pat_out));

    p_tick_chain_r10: assert property (@(posedge clk) disable iff (rst)
        tick_b |-> tick_a);

    p_bit_bound_r4: assert property (@(posedge clk) disable iff (rst)
        running |-> (pos.bit_idx <= cfg.bpw_m1));

    p_word_bound_r5: assert property (@(posedge clk) disable iff (rst)
        running |-> (pos.word <= cfg.len_m1));

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        running |=> $stable(cfg));
endmodule

bind pattern_clk_synth pcs_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stop    (stop),
    .pat_out (pat_out),
    .running (running),
    .tick_a  (tick_a),
    .tick_b  (tick_b),
    .cfg     (cfg_q),
    .pos     (pos_q)
);

// File: tb/sim_pattern_clk_synth.sv
`timescale 1ns/1ps
module sim_pattern_clk_synth;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, stop = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_data = 8'd0;
    logic        buf_we = 1'b0;
    logic [5:0]  buf_addr = 6'd0;
    logic [31:0] buf_wdata = 32'd0;
    logic        pat_out;

    logic [31:0] pat [64];
    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pattern_clk_synth u0 (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .pat_out(pat_out)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic check(input logic act, input logic exp, input string rq);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", rq, act, exp, $time);
        end
    endtask

    // all drive tasks are entered and left at a falling edge
    task automatic wcfg(input int sel, input int val);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic bwrite(input int a, input logic [31:0] d);
        buf_we = 1'b1; buf_addr = 6'(a); buf_wdata = d;
        pat[a] = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic logic exp_bit(input int idx, input int bpw, input int len);
        int w = (idx / bpw) % len;
        int b = 31 - (idx % bpw);
        return pat[w][b];
    endfunction

    task automatic stop_now(input string rq);
        bit stayed = 1'b1;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(pat_out, 1'b0, rq);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pat_out !== 1'b0) stayed = 1'b0;
        end
        check(stayed, 1'b1, rq);
    endtask

    task automatic play(input int d1, input int d2, input int bpw, input int len,
                        input int nbits, input int restart_at, input int inject_at,
                        input string rq);
        int n = d1 * d2;
        int idx = 0;
        wcfg(0, d1 - 1);
        wcfg(1, d2 - 1);
        wcfg(2, bpw - 1);
        wcfg(3, len - 1);
        do_start();
        for (int j = 0; j < nbits; j++) begin
            repeat (n) @(posedge clk);
            @(negedge clk);
            buf_we = 1'b0;
            cfg_we = 1'b0;
            check(pat_out, exp_bit(idx, bpw, len), rq);
            idx++;
            if (j == restart_at) begin
                do_start();           // R9: restart mid-stream
                idx = 0;
            end
            if (j == inject_at) begin // R8: writes while running
                buf_we = 1'b1; buf_addr = 6'd0; buf_wdata = ~pat[0];
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 8'd7;
            end
        end
        stop_now("R7");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(pat_out, 1'b0, "R1");
        rst = 1'b0;
        @(negedge clk);

        for (int w = 0; w < 64; w++) bwrite(w, 32'hFFFF_FFFF);
        begin
            bit low = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (pat_out !== 1'b0) low = 1'b0;
            end
            check(low, 1'b1, "R1");
        end

        for (int w = 0; w < 64; w++) bwrite(w, $urandom());

        play(1, 1, 32, 1, 40, -1, -1, "R3");
        play(2, 3, 32, 2, 70, -1, -1, "R2");
        play(1, 1, 5, 3, 30, -1, -1, "R4");
        play(1, 1, 3, 4, 30, -1, -1, "R5");
        play(1, 1, 2, 20, 48, -1, -1, "R6");
        play(256, 1, 4, 1, 6, -1, -1, "R10");
        play(1, 256, 4, 1, 4, -1, -1, "R10");
        play(1, 2, 8, 2, 30, 10, -1, "R9");
        play(1, 1, 4, 2, 20, -1, 3, "R8");
        play(1, 1, 4, 2, 20, -1, -1, "R8");

        // mark/space clock: 3 ones then 5 zeros, two periods per 16-bit word
        bwrite(0, 32'hE0E0_0000);
        play(2, 2, 16, 1, 40, -1, -1, "R2");

        for (int c = 0; c < 6; c++) begin
            int d1 = $urandom_range(1, 4);
            int d2 = $urandom_range(1, 3);
            int bpw = $urandom_range(1, 32);
            int len = $urandom_range(1, 40);
            int nb = bpw * len + 24;
            if (nb > 400) nb = 400;
            for (int w = 0; w < 64; w++) bwrite(w, $urandom());
            play(d1, d2, bpw, len, nb, -1, -1, "R5");
        end

        // stop together with start: stop wins
        bwrite(0, 32'hFFFF_FFFF);
        wcfg(0, 0); wcfg(1, 0); wcfg(2, 31); wcfg(3, 0);
        do_start();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(pat_out, 1'b1, "R3");
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check(pat_out, 1'b0, "R7");
        begin
            bit low = 1'b1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (pat_out !== 1'b0) low = 1'b0;
            end
            check(low, 1'b1, "R7");
        end

        finish_run();
    end
endmodule